// File: doc/BRIEF.md
# Register-Triggered Memory Fill Engine

This block fills a region of memory with a repeated 32-bit pattern. It has two independent fill channels. Software sets up each channel through four 32-bit registers: a start address, an end address, a size word and a fill value. Writing the fill value is what launches the fill. No separate start bit exists.

Once launched, a channel writes the byte-reversed fill value to every word from the start address up to, but not including, the end address, in ascending order. It uses a word-wide memory write port that has a ready handshake. Both channels share that port, and channel 0 wins when both are waiting. Each channel reports a busy flag and a sticky done flag.

Register accesses that are not full aligned 32-bit words are ignored, and so are accesses past the last register. The size word is kept and can be read back, but it has no effect on how far a fill runs.

Top module: `memfill_engine`

## Requirements
- R1: Registers are addressed by byte address, word index = bus_addr[7:2]. Channel c uses indices 4c..4c+3, holding start, end, size and value in that order. A read returns the register on bus_rdata one clock after the read is presented.
- R2: A write to index 3 (channel 0) or 7 (channel 1) launches that channel's fill when its start register is nonzero. fill_busy is high on the clock after the write, and mem_we drives the first word on that same clock.
- R3: If the start register is zero when the value write arrives, nothing is written to memory and fill_busy and fill_done keep their values.
- R4: A fill writes word addresses from start rounded down to a multiple of 4, up to end rounded down to a multiple of 4 (exclusive), stepping by 4 in ascending order.
- R5: Every stored word equals the fill value with its byte order reversed: byte 0 and byte 3 swap, and byte 1 and byte 2 swap.
- R6: The size register is stored and can be read back, but it has no effect on the number of words written.
- R7: An access is ignored when bus_size is not 2 (word), when bus_addr[1:0] is not 0, or when the index is 8 or above. An ignored write changes no register and starts nothing. An ignored read returns 0.
- R8: A word is accepted on each clock where mem_we and mem_ready are both high. While mem_ready is low, mem_addr and mem_wdata hold steady.
- R9: fill_busy stays high until the clock where the last word is accepted, and fill_done rises on that same clock. fill_done clears when a new fill launches. A launch with an empty range (end word not above start word) sets fill_done and writes nothing. mem_we is never high while no channel is busy.
- R10: When both channels have words pending and no stalled write is held, channel 0 gets the port. Channel 1 gets it only after channel 0 has finished.
- R11: A value write that arrives while the same channel is busy is stored at once, and the current fill continues with the old pattern. When that fill ends, a second fill runs using the registers as they stand then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access present this clock |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access width: 0 byte, 1 half, 2 word, 3 double |
| bus_addr | input | BUS_AW (8) | Byte address within the register block |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data, valid one clock after the read |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address of the word being written |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the word on this clock |
| fill_busy | output | NUM_CH (2) | Per-channel fill in progress |
| fill_done | output | NUM_CH (2) | Per-channel sticky completion flag |

## Verification
A value write presented before clock edge e makes fill_busy high and puts the first word on mem_we right after edge e. When mem_ready is held high, word k is accepted at edge e+1+k. A read returns its data right after the edge that takes it. The bench changes inputs only on falling edges, or a short delay after a rising edge. It logs every accepted word on the falling edge before the edge that takes it, and checks flags only after polling on falling edges shows the fill has gone idle. Address, order, data and word count are all judged from the log, so stall patterns on mem_ready change the timing but not the expected values.

// File: rtl/memfill_pkg.sv
// Shared constants, access encodings and helpers for the memory fill engine.
// Assumes 32-bit registers and 32-bit memory words throughout.
package memfill_pkg;

    localparam int WORD_W      = 32;
    localparam int REGS_PER_CH = 4;

    // Register slot inside one channel group; order is decoded by the trigger
    localparam int SLOT_START = 0;
    localparam int SLOT_STOP  = 1;
    localparam int SLOT_SIZE  = 2;
    localparam int SLOT_VALUE = 3;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_HALF  = 2'd1,
        ACC_WORD  = 2'd2,
        ACC_DWORD = 2'd3
    } acc_size_e;

    // Reverse byte order of a 32-bit word
    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/memfill_regs.sv
// Register file for all fill channels: decodes word-only accesses, stores
// start/stop/size/value per channel, returns read data one clock later and
// raises a one-clock trigger when a channel's value slot is written.
// Assumes bus_addr is a byte address; low two bits must be zero.
module memfill_regs
    import memfill_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int BUS_AW = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_valid,
    input  logic                          bus_write,
    input  logic [1:0]                    bus_size,
    input  logic [BUS_AW-1:0]             bus_addr,
    input  logic [WORD_W-1:0]             bus_wdata,
    output logic [WORD_W-1:0]             bus_rdata,
    output logic [NUM_CH-1:0][WORD_W-1:0] cfg_start,
    output logic [NUM_CH-1:0][WORD_W-1:0] cfg_stop,
    output logic [NUM_CH-1:0][WORD_W-1:0] cfg_value,
    output logic [NUM_CH-1:0]             trig
);

    localparam int NUM_REGS = NUM_CH * REGS_PER_CH;
    localparam int RIDX_W   = $clog2(NUM_REGS);
    localparam int IDX_W    = BUS_AW - 2;

    logic [WORD_W-1:0] regs_q [NUM_REGS];
    logic [IDX_W-1:0]  idx;
    logic [RIDX_W-1:0] ridx;
    logic              legal;
    logic              wr_ok;

    // Decode whether this access is a legal aligned word inside the block
    always_comb begin
        idx   = bus_addr[BUS_AW-1:2];
        ridx  = idx[RIDX_W-1:0];
        legal = (bus_size == ACC_WORD) && (bus_addr[1:0] == 2'b00) &&
                (int'(idx) < NUM_REGS);
        wr_ok = bus_valid && bus_write && legal;
    end

    // Store register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else if (wr_ok) begin
            regs_q[ridx] <= bus_wdata;
        end
    end

    // Registered read port; illegal reads return zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_valid && !bus_write) begin
            bus_rdata <= legal ? regs_q[ridx] : '0;
        end
    end

    // Per-channel views and value-slot trigger
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign cfg_start[c] = regs_q[c*REGS_PER_CH + SLOT_START];
        assign cfg_stop[c]  = regs_q[c*REGS_PER_CH + SLOT_STOP];
        assign cfg_value[c] = regs_q[c*REGS_PER_CH + SLOT_VALUE];
        assign trig[c]      = wr_ok && (ridx == RIDX_W'(c*REGS_PER_CH + SLOT_VALUE));
    end

    // Size slot is kept only for read-back
    logic unused_size;
    always_comb begin
        unused_size = 1'b0;
        for (int c = 0; c < NUM_CH; c++) unused_size = unused_size | (|regs_q[c*REGS_PER_CH + SLOT_SIZE]);
    end

    AST_IGNORED_WRITE_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_size != ACC_WORD) |-> (trig == '0)); // R7

endmodule

// File: rtl/memfill_channel.sv
// One fill channel: on launch, latches the word range and byte-swapped pattern,
// steps one word per accepted handshake, and re-launches once if a value write
// arrived while busy. Assumes ack is only given while busy.
module memfill_channel
    import memfill_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [WORD_W-1:0] trig_value,
    input  logic [AW-1:0]     cfg_start,
    input  logic [AW-1:0]     cfg_stop,
    input  logic [WORD_W-1:0] cfg_value,
    input  logic              ack,
    output logic              req,
    output logic [AW-1:0]     addr,
    output logic [WORD_W-1:0] data,
    output logic              busy,
    output logic              done
);

    localparam int WA_W = AW - 2;

    logic [WA_W-1:0]   cur_w, end_w;
    logic [WORD_W-1:0] pattern;
    logic              busy_q, done_q, pending_q;
    logic              start_nz, trig_ok, last_ack, launch, range_ok;
    logic [WORD_W-1:0] launch_val;

    // Launch and completion decisions
    always_comb begin
        start_nz   = (cfg_start != '0);
        trig_ok    = trig && start_nz;
        last_ack   = busy_q && ack && ((cur_w + WA_W'(1)) == end_w);
        launch     = busy_q ? (last_ack && (pending_q || trig_ok)) : trig_ok;
        range_ok   = cfg_start[AW-1:2] < cfg_stop[AW-1:2];
        launch_val = trig ? trig_value : cfg_value;
    end

    // Fill sequencer state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            cur_w   <= '0;
            end_w   <= '0;
            pattern <= '0;
        end else if (launch && start_nz && range_ok) begin
            busy_q  <= 1'b1;
            done_q  <= 1'b0;
            cur_w   <= cfg_start[AW-1:2];
            end_w   <= cfg_stop[AW-1:2];
            pattern <= swap_bytes(launch_val);
        end else if (launch || last_ack) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
        end else if (busy_q && ack) begin
            cur_w   <= cur_w + WA_W'(1);
        end
    end

    // Remember a value write that arrives mid-fill
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_q || launch) pending_q <= 1'b0;
        else if (trig_ok)               pending_q <= 1'b1;
    end

    assign req  = busy_q;
    assign addr = {cur_w, 2'b00};
    assign data = pattern;
    assign busy = busy_q;
    assign done = done_q;

    logic unused_stop;
    assign unused_stop = |cfg_stop[1:0];

    AST_STEP_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && ack && !last_ack) |=> busy_q && (cur_w == $past(cur_w) + WA_W'(1))); // R4
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !ack) |=> busy_q && $stable(cur_w) && $stable(pattern)); // R8
    AST_ZERO_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !start_nz && !busy_q) |=> !busy_q && (done_q == $past(done_q))); // R3
    AST_DONE_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> !done_q); // R9
    AST_ACK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> busy_q); // R8

endmodule

// File: rtl/memfill_arb.sv
// Fixed-priority port sharer: lowest channel index wins, but a write that was
// presented and not accepted keeps its owner until it is taken.
// Assumes a requesting channel holds req until it gets its final ack.
module memfill_arb
    import memfill_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int AW     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0]             req,
    input  logic [NUM_CH-1:0][AW-1:0]     ch_addr,
    input  logic [NUM_CH-1:0][WORD_W-1:0] ch_data,
    input  logic                          mem_ready,
    output logic [NUM_CH-1:0]             ack,
    output logic                          mem_we,
    output logic [AW-1:0]                 mem_addr,
    output logic [WORD_W-1:0]             mem_wdata
);

    localparam int OW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [OW-1:0] sel, owner_q;
    logic          locked_q;

    // Pick the owner: held owner while stalled, else lowest requesting index
    always_comb begin
        sel = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (req[c]) sel = OW'(c);
        end
        if (locked_q) sel = owner_q;
    end

    // Lock the owner when its word is presented but not taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            owner_q  <= '0;
        end else begin
            locked_q <= mem_we && !mem_ready;
            owner_q  <= sel;
        end
    end

    assign mem_we    = |req;
    assign mem_addr  = ch_addr[sel];
    assign mem_wdata = ch_data[sel];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ack
        assign ack[c] = mem_we && mem_ready && (sel == OW'(c));
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack)); // R10
    AST_LOW_INDEX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_q && req[0]) |-> (ack[0] == mem_ready)); // R10
    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_ready) |=> mem_we && $stable(mem_addr) && $stable(mem_wdata)); // R8

endmodule

// File: rtl/memfill_engine.sv
// Top of the memory fill engine: register file, one sequencer per channel and
// a shared fixed-priority memory write port.
// Assumes the memory accepts a word on any clock where mem_we and mem_ready are high.
module memfill_engine
    import memfill_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int BUS_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    output logic [NUM_CH-1:0] fill_busy,
    output logic [NUM_CH-1:0] fill_done
);

    localparam int AW = 32;

    logic [NUM_CH-1:0][AW-1:0]     cfg_start, cfg_stop, ch_addr;
    logic [NUM_CH-1:0][WORD_W-1:0] cfg_value, ch_data;
    logic [NUM_CH-1:0]             trig, req, ack;

    memfill_regs #(.NUM_CH(NUM_CH), .BUS_AW(BUS_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_start (cfg_start),
        .cfg_stop  (cfg_stop),
        .cfg_value (cfg_value),
        .trig      (trig)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        memfill_channel #(.AW(AW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .trig       (trig[c]),
            .trig_value (bus_wdata),
            .cfg_start  (cfg_start[c]),
            .cfg_stop   (cfg_stop[c]),
            .cfg_value  (cfg_value[c]),
            .ack        (ack[c]),
            .req        (req[c]),
            .addr       (ch_addr[c]),
            .data       (ch_data[c]),
            .busy       (fill_busy[c]),
            .done       (fill_done[c])
        );
    end

    memfill_arb #(.NUM_CH(NUM_CH), .AW(AW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .ch_addr   (ch_addr),
        .ch_data   (ch_data),
        .mem_ready (mem_ready),
        .ack       (ack),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    AST_NO_WRITE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (fill_busy != '0)); // R9
    AST_LAUNCH_STARTS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_busy[0]) |-> mem_we); // R2

endmodule

// File: tb/sim_memfill_engine.sv
// Self-checking bench for memfill_engine: a vector table of fills followed by
// directed tests for reset, ignored accesses, priority, re-trigger and empty ranges.
module sim_memfill_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b1;
    logic [1:0]  fill_busy, fill_done;

    int checks = 0;
    int fails  = 0;
    int rdy_mode = 0;     // 0 always ready, 1 stall pattern, 2 never ready
    int cyc = 0;

    logic [31:0] log_addr [512];
    logic [31:0] log_data [512];
    int          log_n = 0;

    always #10 clk = ~clk;  // 50 MHz

    memfill_engine u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .fill_busy(fill_busy), .fill_done(fill_done)
    );

    // Record each word the memory will accept at the next rising edge
    always @(negedge clk) begin
        if (mem_we && mem_ready && log_n < 512) begin
            log_addr[log_n] = mem_addr;
            log_data[log_n] = mem_wdata;
            log_n = log_n + 1;
        end
    end

    // Drive mem_ready shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            cyc = cyc + 1;
            case (rdy_mode)
                0: mem_ready = 1'b1;
                1: mem_ready = (cyc % 3) != 1;
                default: mem_ready = 1'b0;
            endcase
        end
    end

    function automatic logic [31:0] bsw(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_acc(input logic wr, input int idx, input logic [31:0] d,
                           input logic [1:0] sz, input logic [1:0] lo);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_size = sz;
        bus_addr = 8'((idx << 2) | lo); bus_wdata = d;
        @(posedge clk);
        #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        bus_acc(1'b1, idx, d, 2'd2, 2'd0);
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        bus_acc(1'b0, idx, 32'h0, 2'd2, 2'd0);
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (fill_busy == 2'b00) break;
        end
    endtask

    typedef struct packed {
        logic        ch;
        logic [31:0] start;
        logic [31:0] stop;
        logic [31:0] size;
        logic [31:0] value;
        logic        stall;
        logic [7:0]  words;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b0, 32'h0000_1000, 32'h0000_1010, 32'h0000_0999, 32'h1122_3344, 1'b0, 8'd4},
        '{1'b1, 32'h0000_2000, 32'h0000_2020, 32'h0000_0000, 32'hA1B2_C3D4, 1'b1, 8'd8},
        '{1'b0, 32'h0000_3002, 32'h0000_3007, 32'h0000_0040, 32'hDEAD_BEEF, 1'b1, 8'd1},
        '{1'b1, 32'h0000_0004, 32'h0000_0008, 32'h0000_0003, 32'h00FF_00FF, 1'b0, 8'd1}
    };

    // Watchdog: an expired run counts as a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int base, bad;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state
        @(negedge clk);
        check("R9 reset busy", {30'h0, fill_busy}, 32'h0);
        check("R9 reset done", {30'h0, fill_done}, 32'h0);
        check("R8 reset mem_we", {31'h0, mem_we}, 32'h0);
        rd(0, rv);
        check("R1 reset reg value", rv, 32'h0);

        // Empty range on channel 0: done set, no writes
        base = log_n;
        wr(0, 32'h7010); wr(1, 32'h7010); wr(3, 32'h5555_AAAA);
        check("R9 empty range busy", {31'h0, fill_busy[0]}, 32'h0);
        repeat (4) @(negedge clk);
        check("R9 empty range writes", 32'(log_n - base), 32'h0);
        check("R9 empty range done", {31'h0, fill_done[0]}, 32'h1);

        // Vector table
        for (int v = 0; v < 4; v++) begin
            int o;
            o = VECS[v].ch ? 4 : 0;
            rdy_mode = VECS[v].stall ? 1 : 0;
            wr(o + 0, VECS[v].start); wr(o + 1, VECS[v].stop); wr(o + 2, VECS[v].size);
            base = log_n;
            wr(o + 3, VECS[v].value);
            check("R2 busy after value write", {31'h0, fill_busy[VECS[v].ch]}, 32'h1);
            check("R9 done cleared at launch", {31'h0, fill_done[VECS[v].ch]}, 32'h0);
            wait_idle();
            check("R6 word count ignores size", 32'(log_n - base), 32'(VECS[v].words));
            bad = 0;
            for (int k = 0; k < int'(VECS[v].words); k++) begin
                if (log_addr[base + k] !== ((VECS[v].start & 32'hFFFF_FFFC) + 32'(4 * k))) bad++;
            end
            check("R4 ascending word addresses", 32'(bad), 32'h0);
            bad = 0;
            for (int k = 0; k < int'(VECS[v].words); k++) begin
                if (log_data[base + k] !== bsw(VECS[v].value)) bad++;
            end
            check("R5 byte-reversed data", 32'(bad), 32'h0);
            check("R9 done after fill", {31'h0, fill_done[VECS[v].ch]}, 32'h1);
            rd(o + 2, rv);
            check("R6 size readback", rv, VECS[v].size);
        end
        rdy_mode = 0;

        // Start address zero: nothing happens
        base = log_n;
        wr(4, 32'h0); wr(5, 32'h100);
        wr(7, 32'h1234_5678);
        check("R3 zero start busy", {31'h0, fill_busy[1]}, 32'h0);
        repeat (4) @(negedge clk);
        check("R3 zero start writes", 32'(log_n - base), 32'h0);
        check("R3 zero start done kept", {31'h0, fill_done[1]}, 32'h1);

        // Ignored accesses: byte-wide, misaligned and out-of-range
        wr(0, 32'h0000_0100); wr(1, 32'h0000_0200);
        base = log_n;
        bus_acc(1'b1, 3, 32'hCAFE_F00D, 2'd0, 2'd0);
        bus_acc(1'b1, 3, 32'hCAFE_F00D, 2'd2, 2'd1);
        check("R7 narrow or misaligned write no launch", {31'h0, fill_busy[0]}, 32'h0);
        rd(3, rv);
        check("R7 value reg unchanged", rv, 32'h1122_3344 ^ 32'h0 ^ (VECS[2].value ^ 32'h1122_3344));
        bus_acc(1'b1, 8, 32'hFFFF_FFFF, 2'd2, 2'd0);
        bus_acc(1'b0, 8, 32'h0, 2'd2, 2'd0);
        check("R7 out-of-range read zero", bus_rdata, 32'h0);
        bus_acc(1'b0, 0, 32'h0, 2'd1, 2'd0);
        check("R7 narrow read zero", bus_rdata, 32'h0);
        rd(0, rv);
        check("R7 start reg unchanged", rv, 32'h0000_0100);
        repeat (3) @(negedge clk);
        check("R7 no writes from ignored access", 32'(log_n - base), 32'h0);

        // Priority: channel 0 then channel 1 back to back
        wr(0, 32'h4000); wr(1, 32'h4010);
        wr(4, 32'h5000); wr(5, 32'h5008);
        base = log_n;
        wr(3, 32'h0102_0304);
        wr(7, 32'h0506_0708);
        check("R10 channel 1 waits busy", {31'h0, fill_busy[1]}, 32'h1);
        wait_idle();
        check("R10 total words", 32'(log_n - base), 32'd6);
        bad = 0;
        for (int k = 0; k < 4; k++) if (log_addr[base + k] !== 32'h4000 + 32'(4 * k)) bad++;
        for (int k = 0; k < 2; k++) if (log_addr[base + 4 + k] !== 32'h5000 + 32'(4 * k)) bad++;
        check("R10 channel 0 words first", 32'(bad), 32'h0);

        // Re-trigger while busy
        rdy_mode = 2;
        wr(0, 32'h6000); wr(1, 32'h6008);
        base = log_n;
        wr(3, 32'hAABB_CCDD);
        wr(3, 32'h1020_3040);
        rd(3, rv);
        check("R11 value stored while busy", rv, 32'h1020_3040);
        rdy_mode = 0;
        wait_idle();
        check("R11 two fills of words", 32'(log_n - base), 32'd4);
        bad = 0;
        for (int k = 0; k < 2; k++) begin
            if (log_data[base + k] !== bsw(32'hAABB_CCDD)) bad++;
            if (log_data[base + 2 + k] !== bsw(32'h1020_3040)) bad++;
            if (log_addr[base + 2 + k] !== 32'h6000 + 32'(4 * k)) bad++;
        end
        check("R11 old pattern then new pattern", 32'(bad), 32'h0);
        check("R9 done after re-trigger", {31'h0, fill_done[0]}, 32'h1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule